// File: doc/BRIEF.md
# Vector Unpack Zero-Extend Unit

This unit widens packed narrow elements from one or two source vectors of a fixed width VL into vectors whose elements are twice as wide. Each source vector is split at its midpoint. The narrow elements of the lower half are zero-extended into one destination vector, and the elements of the upper half are zero-extended into the next. Element order is kept inside each half. Every destination element is written; there is no predication.

The unit also decodes the instruction fields. These are a 2-bit width code, a pair/quad selector, a source register field and a destination register field. From them it produces the source read indices, the first destination register number and a per-destination write mask. The reserved width code, or a streaming enable that is low, yields an undefined-instruction flag with no writes. The datapath is combinational. It is followed by an optional output register, which gives a one-cycle valid latency.

Top module: `vunpk_top`

## Requirements
- R1: Width code 2'b01 gives 16-bit destination elements: destination element e holds source byte e of its half in bits [7:0], and bits [15:8] are zero.
- R2: Width code 2'b10 gives 32-bit destination elements, each holding one 16-bit source element in its low half with the upper 16 bits zero.
- R3: Width code 2'b11 gives 64-bit destination elements, each holding one 32-bit source element in its low half with the upper 32 bits zero.
- R4: For source r (0 = `src_a`, 1 = `src_b`), the narrow elements in the lower VL/2 bits go to destination 2r and those in the upper VL/2 bits go to destination 2r+1, with element order kept within each half.
- R5: Width code 2'b00 is reserved. An accepted operation with that code sets `out_undef`, clears `out_wr_mask`, and drives all destination data and `out_dst_base` to zero.
- R6: An accepted operation with `stream_en` low sets `out_undef`, clears `out_wr_mask`, and drives all destination data to zero, whatever the width code.
- R7: When `quad_mode` = 0, `rd_idx0` and `rd_idx1` both equal `src_field`. `out_dst_base` is `{dst_field, 1'b0}`, and `out_wr_mask` is 4'b0011. Destinations 2 and 3 read as zero.
- R8: When `quad_mode` = 1, `rd_idx0` is `{src_field[3:0], 1'b0}` and `rd_idx1` is that value plus 1. `out_dst_base` is `{dst_field[2:0], 2'b00}` and `out_wr_mask` is 4'b1111. `src_field[4]` and `dst_field[3]` are ignored.
- R9: With the output register present, the results of an operation presented with `in_valid` high appear with `out_valid` high on the next clock edge. A cycle with `in_valid` low yields `out_valid` = 0, `out_undef` = 0 and `out_wr_mask` = 0. Back-to-back operations are accepted every cycle.
- R10: While `rst_n` is low, `out_valid`, `out_undef`, `out_wr_mask`, `out_dst_base` and all destination data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| stream_en | input | 1 | Streaming-mode enable; low makes the operation undefined |
| size_code | input | 2 | Destination element width code (00 reserved, 01=16, 10=32, 11=64 bits) |
| quad_mode | input | 1 | 0: one source to two destinations; 1: two sources to four destinations |
| src_field | input | 5 | Encoded source register field |
| dst_field | input | 4 | Encoded destination register field |
| src_a | input | VL | Data of the first source register |
| src_b | input | VL | Data of the second source register (quad mode) |
| rd_idx0 | output | 5 | Register number of the first source read |
| rd_idx1 | output | 5 | Register number of the second source read |
| out_valid | output | 1 | Result valid |
| out_undef | output | 1 | Undefined-instruction indication |
| out_wr_mask | output | 4 | Write enable per destination, bit k for destination base+k |
| out_dst_base | output | 5 | First destination register number |
| out_dst0 | output | VL | Destination base+0 data |
| out_dst1 | output | VL | Destination base+1 data |
| out_dst2 | output | VL | Destination base+2 data |
| out_dst3 | output | VL | Destination base+3 data |

## Verification
The two undefined-instruction causes, the reserved width code and a low streaming enable, can occur in the same operation. The bench provokes this with a vector that carries width code 00 and has `stream_en` low. It judges the result by a single raised `out_undef`, an all-zero write mask and all-zero destination data. Decode and data selection also coincide when a quad operation follows a pair operation on the very next cycle. The table walk does this, and each registered result is compared against a bit-level model computed in the bench.

// File: rtl/vunpk_pkg.sv
package vunpk_pkg;

  localparam int unsigned REG_W   = 5;
  localparam int unsigned NUM_DST = 4;

  typedef enum logic [1:0] {
    SZ_RSVD = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBL  = 2'b11
  } width_code_e;

  typedef struct packed {
    logic               undef;
    logic               legal;
    logic [NUM_DST-1:0] wr_mask;
    logic [REG_W-1:0]   dst_base;
    logic [REG_W-1:0]   rd0;
    logic [REG_W-1:0]   rd1;
  } dec_t;

  // destination element width in bits for a width code
  function automatic int unsigned dst_bits(input logic [1:0] code);
    return 32'd8 << code;
  endfunction

  function automatic logic [REG_W-1:0] pair_dst_base(input logic [3:0] fld);
    return {fld, 1'b0};
  endfunction

  function automatic logic [REG_W-1:0] quad_dst_base(input logic [2:0] fld);
    return {fld, 2'b00};
  endfunction

  function automatic logic [REG_W-1:0] quad_src_base(input logic [3:0] fld);
    return {fld, 1'b0};
  endfunction

endpackage

// File: rtl/vunpk_decode.sv
module vunpk_decode
  import vunpk_pkg::*;
(
  input  logic             valid,
  input  logic             stream_en,
  input  logic [1:0]       size_code,
  input  logic             quad_mode,
  input  logic [REG_W-1:0] src_field,
  input  logic [3:0]       dst_field,
  output dec_t             dec
);

  logic rsvd_size;
  logic blocked;

  assign rsvd_size = (width_code_e'(size_code) == SZ_RSVD);
  assign blocked   = !stream_en;

  always_comb begin
    dec       = '0;
    dec.undef = valid && (rsvd_size || blocked);
    dec.legal = valid && !rsvd_size && !blocked;
    if (quad_mode) begin
      dec.rd0 = quad_src_base(src_field[3:0]);
      dec.rd1 = quad_src_base(src_field[3:0]) | 5'd1;
    end else begin
      dec.rd0 = src_field;
      dec.rd1 = src_field;
    end
    if (dec.legal) begin
      dec.wr_mask  = quad_mode ? 4'b1111 : 4'b0011;
      dec.dst_base = quad_mode ? quad_dst_base(dst_field[2:0])
                               : pair_dst_base(dst_field);
    end
  end

endmodule

// File: rtl/vunpk_lane.sv
module vunpk_lane
  import vunpk_pkg::*;
#(
  parameter int unsigned VL = 128
) (
  input  logic [VL-1:0] src,
  input  logic [1:0]    size_code,
  output logic [VL-1:0] lo_dst,
  output logic [VL-1:0] hi_dst
);

  logic [VL-1:0] lo_w [1:3];
  logic [VL-1:0] hi_w [1:3];

  // one widening network per legal width code
  for (genvar w = 1; w < 4; w++) begin : g_width
    localparam int unsigned ESZ = 8 << w;
    localparam int unsigned HSZ = ESZ / 2;
    localparam int unsigned NEL = VL / ESZ;
    for (genvar e = 0; e < NEL; e++) begin : g_elem
      assign lo_w[w][e*ESZ +: ESZ] = {{HSZ{1'b0}}, src[e*HSZ +: HSZ]};
      assign hi_w[w][e*ESZ +: ESZ] = {{HSZ{1'b0}}, src[(NEL+e)*HSZ +: HSZ]};
    end
  end

  always_comb begin
    unique case (width_code_e'(size_code))
      SZ_HALF: begin lo_dst = lo_w[1]; hi_dst = hi_w[1]; end
      SZ_WORD: begin lo_dst = lo_w[2]; hi_dst = hi_w[2]; end
      SZ_DBL:  begin lo_dst = lo_w[3]; hi_dst = hi_w[3]; end
      default: begin lo_dst = '0;      hi_dst = '0;      end
    endcase
  end

endmodule

// File: rtl/vunpk_top.sv
module vunpk_top
  import vunpk_pkg::*;
#(
  parameter int unsigned VL      = 128,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             stream_en,
  input  logic [1:0]       size_code,
  input  logic             quad_mode,
  input  logic [4:0]       src_field,
  input  logic [3:0]       dst_field,
  input  logic [VL-1:0]    src_a,
  input  logic [VL-1:0]    src_b,
  output logic [4:0]       rd_idx0,
  output logic [4:0]       rd_idx1,
  output logic             out_valid,
  output logic             out_undef,
  output logic [3:0]       out_wr_mask,
  output logic [4:0]       out_dst_base,
  output logic [VL-1:0]    out_dst0,
  output logic [VL-1:0]    out_dst1,
  output logic [VL-1:0]    out_dst2,
  output logic [VL-1:0]    out_dst3
);

  localparam int unsigned NSRC = NUM_DST / 2;

  dec_t          dec;
  logic [VL-1:0] srcs   [NSRC];
  logic [VL-1:0] widen  [NUM_DST];
  logic [VL-1:0] dst_c  [NUM_DST];

  vunpk_decode i_decode (
    .valid     (in_valid),
    .stream_en (stream_en),
    .size_code (size_code),
    .quad_mode (quad_mode),
    .src_field (src_field),
    .dst_field (dst_field),
    .dec       (dec)
  );

  assign rd_idx0 = dec.rd0;
  assign rd_idx1 = dec.rd1;
  assign srcs[0] = src_a;
  assign srcs[1] = src_b;

  for (genvar r = 0; r < NSRC; r++) begin : g_src
    vunpk_lane #(.VL(VL)) i_lane (
      .src       (srcs[r]),
      .size_code (size_code),
      .lo_dst    (widen[2*r]),
      .hi_dst    (widen[2*r+1])
    );
  end

  for (genvar k = 0; k < NUM_DST; k++) begin : g_gate
    assign dst_c[k] = dec.wr_mask[k] ? widen[k] : '0;
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid    <= 1'b0;
        out_undef    <= 1'b0;
        out_wr_mask  <= '0;
        out_dst_base <= '0;
        out_dst0     <= '0;
        out_dst1     <= '0;
        out_dst2     <= '0;
        out_dst3     <= '0;
      end else begin
        out_valid    <= in_valid;
        out_undef    <= dec.undef;
        out_wr_mask  <= dec.wr_mask;
        out_dst_base <= dec.dst_base;
        out_dst0     <= dst_c[0];
        out_dst1     <= dst_c[1];
        out_dst2     <= dst_c[2];
        out_dst3     <= dst_c[3];
      end
    end

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_undef && out_wr_mask == 4'b0000));
    assert_reserved_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && size_code == 2'b00) |=> (out_undef && out_wr_mask == 4'b0000));
    assert_disabled_undef_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !stream_en) |=> (out_undef && out_dst0 == '0 && out_dst1 == '0));
    assert_pair_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && stream_en && size_code != 2'b00 && !quad_mode)
        |=> (out_wr_mask == 4'b0011 && out_dst2 == '0 && out_dst3 == '0));
    assert_quad_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && stream_en && size_code != 2'b00 && quad_mode)
        |=> (out_wr_mask == 4'b1111 && out_dst_base[1:0] == 2'b00));
    assert_undef_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_undef |-> (out_valid && out_wr_mask == 4'b0000));
  end else begin : g_comb
    assign out_valid    = in_valid;
    assign out_undef    = dec.undef;
    assign out_wr_mask  = dec.wr_mask;
    assign out_dst_base = dec.dst_base;
    assign out_dst0     = dst_c[0];
    assign out_dst1     = dst_c[1];
    assign out_dst2     = dst_c[2];
    assign out_dst3     = dst_c[3];
  end

endmodule

// File: tb/test_vunpk_top.sv
module test_vunpk_top;

  localparam int unsigned VL = 128;
  // entry: {quad[44], size[43:42], en[41], sfield[40:36], dfield[35:32], seed[31:0]}
  localparam int NV = 13;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 2'b01, 1'b1, 5'd3,  4'd2,  32'h1234_5678},
    {1'b0, 2'b10, 1'b1, 5'd9,  4'd5,  32'h8BAD_F00D},
    {1'b0, 2'b11, 1'b1, 5'd17, 4'd11, 32'hFFFF_FFFF},
    {1'b1, 2'b01, 1'b1, 5'd4,  4'd3,  32'hA5A5_5A5A},
    {1'b1, 2'b10, 1'b1, 5'd7,  4'd6,  32'h0F0F_F0F0},
    {1'b1, 2'b11, 1'b1, 5'd2,  4'd1,  32'hDEAD_BEEF},
    {1'b0, 2'b00, 1'b1, 5'd5,  4'd4,  32'h1111_2222},
    {1'b1, 2'b00, 1'b1, 5'd6,  4'd2,  32'h3333_4444},
    {1'b0, 2'b10, 1'b0, 5'd8,  4'd9,  32'h5555_6666},
    {1'b1, 2'b11, 1'b0, 5'd1,  4'd7,  32'h7777_8888},
    {1'b0, 2'b01, 1'b1, 5'd31, 4'd15, 32'hCAFE_0001},
    {1'b1, 2'b11, 1'b1, 5'd31, 4'd15, 32'h8000_0001},
    {1'b0, 2'b00, 1'b0, 5'd12, 4'd12, 32'h9999_AAAA}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, stream_en, quad_mode;
  logic [1:0]    size_code;
  logic [4:0]    src_field;
  logic [3:0]    dst_field;
  logic [VL-1:0] src_a, src_b;
  logic [4:0]    rd_idx0, rd_idx1;
  logic          out_valid, out_undef;
  logic [3:0]    out_wr_mask;
  logic [4:0]    out_dst_base;
  logic [VL-1:0] out_dst0, out_dst1, out_dst2, out_dst3;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  vunpk_top #(.VL(VL)) i_vunpk_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .stream_en(stream_en),
    .size_code(size_code), .quad_mode(quad_mode), .src_field(src_field),
    .dst_field(dst_field), .src_a(src_a), .src_b(src_b),
    .rd_idx0(rd_idx0), .rd_idx1(rd_idx1), .out_valid(out_valid),
    .out_undef(out_undef), .out_wr_mask(out_wr_mask), .out_dst_base(out_dst_base),
    .out_dst0(out_dst0), .out_dst1(out_dst1), .out_dst2(out_dst2), .out_dst3(out_dst3)
  );

  function automatic logic [VL-1:0] gen_data(input logic [31:0] seed);
    logic [VL-1:0] v;
    for (int w = 0; w < VL/32; w++)
      v[w*32 +: 32] = (seed * (w + 3)) ^ (32'h9E37_79B9 * w) ^ {seed[15:0], seed[31:16]};
    return v;
  endfunction

  // bit-level reference: bit b of destination half `half` at width esz
  function automatic logic [VL-1:0] ref_dst(input logic [VL-1:0] s, input int esz, input int half);
    logic [VL-1:0] v;
    int h, n, e, off;
    h = esz / 2;
    n = VL / esz;
    for (int b = 0; b < VL; b++) begin
      e   = b / esz;
      off = b % esz;
      v[b] = (off < h) ? s[(half*n + e)*h + off] : 1'b0;
    end
    return v;
  endfunction

  function automatic string size_tag(input logic [1:0] sz);
    case (sz)
      2'b01:   return "R1";
      2'b10:   return "R2";
      2'b11:   return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [VL-1:0] act, input logic [VL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [44:0] t);
    in_valid  = v;
    quad_mode = t[44];
    size_code = t[43:42];
    stream_en = t[41];
    src_field = t[40:36];
    dst_field = t[35:32];
    src_a     = gen_data(t[31:0]);
    src_b     = gen_data(t[31:0] ^ 32'h5A5A_C3C3);
  endtask

  task automatic check_rd(input logic [44:0] t);
    logic [4:0] e0, e1;
    if (t[44]) begin e0 = {t[39:36], 1'b0}; e1 = e0 + 5'd1; end
    else       begin e0 = t[40:36];          e1 = t[40:36]; end
    chk(t[44] ? "R8 rd_idx0" : "R7 rd_idx0", VL'(rd_idx0), VL'(e0));
    chk(t[44] ? "R8 rd_idx1" : "R7 rd_idx1", VL'(rd_idx1), VL'(e1));
  endtask

  task automatic check_out(input logic [44:0] t);
    logic          q, ok;
    logic [1:0]    sz;
    int            esz;
    logic [VL-1:0] a, b;
    logic [VL-1:0] exp [4];
    logic [3:0]    emask;
    logic [4:0]    ebase;
    string         tg;
    q   = t[44];
    sz  = t[43:42];
    ok  = (sz != 2'b00) && t[41];
    a   = gen_data(t[31:0]);
    b   = gen_data(t[31:0] ^ 32'h5A5A_C3C3);
    esz = 8 << sz;
    tg  = !t[41] ? "R6" : size_tag(sz);
    for (int k = 0; k < 4; k++) exp[k] = '0;
    emask = 4'b0000;
    ebase = 5'd0;
    if (ok) begin
      exp[0] = ref_dst(a, esz, 0);
      exp[1] = ref_dst(a, esz, 1);
      if (q) begin
        exp[2] = ref_dst(b, esz, 0);
        exp[3] = ref_dst(b, esz, 1);
        emask  = 4'b1111;
        ebase  = {t[34:32], 2'b00};
      end else begin
        emask  = 4'b0011;
        ebase  = {t[35:32], 1'b0};
      end
    end
    chk("R9 out_valid", VL'(out_valid), VL'(1));
    chk({tg, " out_undef"}, VL'(out_undef), VL'(!ok));
    chk(q ? "R8 wr_mask" : "R7 wr_mask", VL'(out_wr_mask), VL'(emask));
    chk(q ? "R8 dst_base" : "R7 dst_base", VL'(out_dst_base), VL'(ebase));
    chk({tg, "/R4 dst0"}, out_dst0, exp[0]);
    chk({tg, "/R4 dst1"}, out_dst1, exp[1]);
    chk({tg, "/R4 dst2"}, out_dst2, exp[2]);
    chk({tg, "/R4 dst3"}, out_dst3, exp[3]);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(1'b1, VEC[5]);
    repeat (3) @(negedge clk);
    // R10: reset holds outputs at zero even with a valid operation present
    chk("R10 out_valid", VL'(out_valid), VL'(0));
    chk("R10 out_undef", VL'(out_undef), VL'(0));
    chk("R10 wr_mask", VL'(out_wr_mask), VL'(0));
    chk("R10 dst_base", VL'(out_dst_base), VL'(0));
    chk("R10 dst0", out_dst0, '0);
    chk("R10 dst3", out_dst3, '0);
    rst_n = 1'b1;
    drive(1'b0, VEC[0]);
    @(negedge clk);

    // table walk, one operation per cycle back to back
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i]);
      #1 check_rd(VEC[i]);
      @(negedge clk);
      check_out(VEC[i]);
    end

    // R9: idle cycle after a legal quad operation shows nothing
    drive(1'b0, VEC[5]);
    @(negedge clk);
    chk("R9 idle out_valid", VL'(out_valid), VL'(0));
    chk("R9 idle out_undef", VL'(out_undef), VL'(0));
    chk("R9 idle wr_mask", VL'(out_wr_mask), VL'(0));

    // R5 with R6 together: idle input with reserved code and enable low stays quiet
    drive(1'b0, VEC[12]);
    @(negedge clk);
    chk("R5 idle undef", VL'(out_undef), VL'(0));

    // R4: distinct halves make low/high swap visible (quad, 16-bit)
    in_valid  = 1'b1; quad_mode = 1'b1; size_code = 2'b01; stream_en = 1'b1;
    src_field = 5'd0; dst_field = 4'd0;
    src_a = {{(VL/2){1'b1}}, {(VL/2){1'b0}}};
    src_b = {{(VL/2){1'b0}}, {(VL/2){1'b1}}};
    @(negedge clk);
    chk("R4 low half a", out_dst0, '0);
    chk("R4 high half a", out_dst1, {(VL/16){16'h00FF}});
    chk("R4 low half b", out_dst2, {(VL/16){16'h00FF}});
    chk("R4 high half b", out_dst3, '0);

    // R1: element order, byte e of low half at element e
    quad_mode = 1'b0;
    for (int e = 0; e < VL/8; e++) src_a[e*8 +: 8] = 8'(e + 1);
    @(negedge clk);
    chk("R1 element 0", VL'(out_dst0[15:0]), VL'(16'h0001));
    chk("R1 last low element", VL'(out_dst0[VL-16 +: 16]), VL'(16'(VL/16)));
    chk("R1 first high element", VL'(out_dst1[15:0]), VL'(16'(VL/16 + 1)));

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule